// File: doc/BRIEF.md
# Dual FIR Output Combiner

This block merges the full-precision results of two independent FIR cells into one output word. In select mode it passes one cell's result, and the choice of cell can change on any clock. In sum mode it adds the two results. Adding them lets two short filters act as one filter of twice the length, or form the sum terms of quadrature and complex filtering.

A rounding stage follows the combine step. Its position is programmable. It adds half of the chosen LSB and then clears every bit below that position. The result is held in one register. The registered word leaves the block as a 9-bit low half and a 19-bit high half, and each half has its own enable. A status output flags a signed overflow in the add or in the rounding step. The FIR cells and their coefficient storage are outside this block.

Top module: `dual_fir_combiner`

## Requirements
- R1: With sum_mode_i = 0, sel_b_i = 0 picks cell A and sel_b_i = 1 picks cell B. The choice takes effect on every clock, so consecutive cycles may select different cells.
- R2: With sum_mode_i = 1, the result is a_data_i + b_data_i at 28-bit two's-complement width, wrapping modulo 2^28.
- R3: ovf_o is 1 for the cycle whose result had a signed overflow, either in the sum-mode add or in the rounding add. In every other case it is 0.
- R4: For rnd_pos_i = p with 1 <= p <= 27, the result is (x + 2^(p-1)) with bits p-1 down to 0 cleared. For p = 0 the word passes unchanged.
- R5: rnd_pos_i values 28 to 31 behave exactly as position 27.
- R6: out_lo_o carries bits 8:0 of the registered result, and out_hi_o carries bits 27:9.
- R7: When oe_lo_i is 0, out_lo_o reads 0. When oe_hi_i is 0, out_hi_o reads 0. The enables act at once, do not touch the other half and do not alter the stored result.
- R8: valid_o follows one clock after its inputs. In select mode it copies the selected cell's valid. In sum mode it is a_valid_i AND b_valid_i.
- R9: Data, valid_o and ovf_o have exactly one clock of latency. While rst_ni is 0, the result register, valid_o and ovf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | 28 | Cell A full-precision result, signed |
| a_valid_i | input | 1 | Cell A result valid |
| b_data_i | input | 28 | Cell B full-precision result, signed |
| b_valid_i | input | 1 | Cell B result valid |
| sum_mode_i | input | 1 | 1: add the cells, 0: select one |
| sel_b_i | input | 1 | Select mode: 1 picks cell B, 0 picks cell A |
| rnd_pos_i | input | 5 | Rounding bit position, 0 = none |
| oe_lo_i | input | 1 | Enable for the low output half |
| oe_hi_i | input | 1 | Enable for the high output half |
| out_lo_o | output | 9 | Result bits 8:0 |
| out_hi_o | output | 19 | Result bits 27:9 |
| valid_o | output | 1 | Result valid |
| ovf_o | output | 1 | Signed overflow in add or rounding |

## Verification
The hardest case to reach from the ports is an overflow that comes only from the rounding carry. The combine step itself produces no overflow here. The stimulus reaches it in two ways. It feeds the largest positive value through select mode with rounding at position 1. It also places a value just above 2^26 under rounding at the top position, reached both directly and through a clamped position. Separately, the vector loop changes mode, select and rounding position on every clock. This shows that no setting leaks from one cycle into the next.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int unsigned DATA_W = 28;
  localparam int unsigned LO_W   = 9;
  localparam int unsigned POS_W  = 5;
endpackage

// File: rtl/comb_path_sel.sv
module comb_path_sel #(
  parameter int unsigned W = 28
) (
  input  logic [W-1:0] a_i,
  input  logic         a_v_i,
  input  logic [W-1:0] b_i,
  input  logic         b_v_i,
  input  logic         sum_mode_i,
  input  logic         sel_b_i,
  output logic [W-1:0] res_o,
  output logic         vld_o,
  output logic         ovf_o
);
  logic [W-1:0] sum;

  assign sum = a_i + b_i;

  always_comb begin
    if (sum_mode_i) begin
      res_o = sum;
      vld_o = a_v_i & b_v_i;
      // same operand signs, different result sign
      ovf_o = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
    end else begin
      res_o = sel_b_i ? b_i : a_i;
      vld_o = sel_b_i ? b_v_i : a_v_i;
      ovf_o = 1'b0;
    end
  end
endmodule

// File: rtl/comb_rounder.sv
module comb_rounder #(
  parameter int unsigned W     = 28,
  parameter int unsigned POS_W = 5
) (
  input  logic [W-1:0]     x_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [W-1:0]     y_o,
  output logic             ovf_o
);
  localparam int unsigned MAX_POS = W - 1;

  logic [31:0]  pos_eff;
  logic [W-1:0] half;
  logic [W-1:0] keep;
  logic [W-1:0] sum;

  always_comb begin
    pos_eff = 32'(pos_i);
    if (pos_eff > MAX_POS) pos_eff = MAX_POS;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign half[g] = (pos_eff == 32'(g + 1));
    assign keep[g] = (32'(g) >= pos_eff);
  end

  assign sum   = x_i + half;
  // half is never negative: overflow only when a positive input turns negative
  assign ovf_o = ~x_i[W-1] & sum[W-1];
  assign y_o   = sum & keep;
endmodule

// File: rtl/dual_fir_combiner.sv
module dual_fir_combiner
  import dfc_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned LW    = LO_W,
  parameter int unsigned PW    = POS_W,
  localparam int unsigned HW   = W - LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_data_i,
  input  logic          a_valid_i,
  input  logic [W-1:0]  b_data_i,
  input  logic          b_valid_i,
  input  logic          sum_mode_i,
  input  logic          sel_b_i,
  input  logic [PW-1:0] rnd_pos_i,
  input  logic          oe_lo_i,
  input  logic          oe_hi_i,
  output logic [LW-1:0] out_lo_o,
  output logic [HW-1:0] out_hi_o,
  output logic          valid_o,
  output logic          ovf_o
);
  logic [W-1:0] comb_res;
  logic         comb_vld;
  logic         comb_ovf;
  logic [W-1:0] rnd_res;
  logic         rnd_ovf;

  logic [W-1:0] res_q;
  logic         vld_q;
  logic         ovf_q;

  comb_path_sel #(.W(W)) i_sel (
    .a_i        (a_data_i),
    .a_v_i      (a_valid_i),
    .b_i        (b_data_i),
    .b_v_i      (b_valid_i),
    .sum_mode_i (sum_mode_i),
    .sel_b_i    (sel_b_i),
    .res_o      (comb_res),
    .vld_o      (comb_vld),
    .ovf_o      (comb_ovf)
  );

  comb_rounder #(.W(W), .POS_W(PW)) i_rnd (
    .x_i   (comb_res),
    .pos_i (rnd_pos_i),
    .y_o   (rnd_res),
    .ovf_o (rnd_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= rnd_res;
      vld_q <= comb_vld;
      ovf_q <= comb_ovf | rnd_ovf;
    end
  end

  assign out_lo_o = oe_lo_i ? res_q[LW-1:0] : '0;
  assign out_hi_o = oe_hi_i ? res_q[W-1:LW] : '0;
  assign valid_o  = vld_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/dual_fir_combiner_chk.sv
module dual_fir_combiner_chk #(
  parameter int unsigned W  = 28,
  parameter int unsigned LW = 9,
  parameter int unsigned PW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  a_data_i,
  input logic          a_valid_i,
  input logic          b_valid_i,
  input logic          sum_mode_i,
  input logic          sel_b_i,
  input logic [PW-1:0] rnd_pos_i,
  input logic          oe_lo_i,
  input logic          oe_hi_i,
  input logic [LW-1:0] out_lo_o,
  input logic [W-LW-1:0] out_hi_o,
  input logic          valid_o,
  input logic          ovf_o,
  input logic [W-1:0]  res_q
);
  p_mux_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sum_mode_i && !sel_b_i && rnd_pos_i == '0) |=> res_q == $past(a_data_i));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sum_mode_i && rnd_pos_i == '0) |=> !ovf_o);

  p_round_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd_pos_i == PW'(4)) |=> res_q[3:0] == 4'h0);

  p_oe_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_lo_i |-> out_lo_o == '0);

  p_oe_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_hi_i |-> out_hi_o == '0);

  p_sum_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_mode_i && a_valid_i && b_valid_i) |=> valid_o);

  p_sum_invalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_mode_i && !(a_valid_i && b_valid_i)) |=> !valid_o);

  p_sel_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sum_mode_i) |=> valid_o == $past(sel_b_i ? b_valid_i : a_valid_i));
endmodule

bind dual_fir_combiner dual_fir_combiner_chk #(.W(W), .LW(LW), .PW(PW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .a_data_i   (a_data_i),
  .a_valid_i  (a_valid_i),
  .b_valid_i  (b_valid_i),
  .sum_mode_i (sum_mode_i),
  .sel_b_i    (sel_b_i),
  .rnd_pos_i  (rnd_pos_i),
  .oe_lo_i    (oe_lo_i),
  .oe_hi_i    (oe_hi_i),
  .out_lo_o   (out_lo_o),
  .out_hi_o   (out_hi_o),
  .valid_o    (valid_o),
  .ovf_o      (ovf_o),
  .res_q      (res_q)
);

// File: tb/test_dual_fir_combiner.sv
`timescale 1ns/1ps
module test_dual_fir_combiner;
  typedef struct packed {
    logic        mode;
    logic        sel;
    logic        va;
    logic        vb;
    logic [27:0] a;
    logic [27:0] b;
    logic [4:0]  pos;
    logic [27:0] exp;
    logic        eovf;
    logic        evld;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 28'd100,       28'd7,         5'd0,  28'd100,       1'b0, 1'b1}, // R1 A
    '{1'b0, 1'b1, 1'b1, 1'b0, 28'd100,       28'hFFFFFFB,   5'd0,  28'hFFFFFFB,   1'b0, 1'b0}, // R1 B, R8
    '{1'b1, 1'b0, 1'b1, 1'b1, 28'd100,       28'hFFFFFFB,   5'd0,  28'd95,        1'b0, 1'b1}, // R2
    '{1'b1, 1'b0, 1'b1, 1'b0, 28'd100,       28'd3,         5'd3,  28'd104,       1'b0, 1'b0}, // R4, R8
    '{1'b1, 1'b1, 1'b1, 1'b1, 28'hFFFFFEC,   28'hFFFFFFD,   5'd4,  28'hFFFFFF0,   1'b0, 1'b1}, // R4 neg
    '{1'b1, 1'b0, 1'b1, 1'b1, 28'h7FFFFFF,   28'd1,         5'd0,  28'h8000000,   1'b1, 1'b1}, // R3 pos wrap
    '{1'b1, 1'b0, 1'b1, 1'b1, 28'h8000000,   28'h8000000,   5'd0,  28'd0,         1'b1, 1'b1}, // R3 neg wrap
    '{1'b0, 1'b0, 1'b1, 1'b1, 28'h7FFFFFF,   28'd0,         5'd1,  28'h8000000,   1'b1, 1'b1}, // R3 round carry
    '{1'b0, 1'b1, 1'b0, 1'b1, 28'd0,         28'h1000000,   5'd31, 28'd0,         1'b0, 1'b1}, // R5
    '{1'b0, 1'b0, 1'b1, 1'b0, 28'hFFFFFFB,   28'd0,         5'd31, 28'd0,         1'b0, 1'b1}, // R5 neg
    '{1'b0, 1'b0, 1'b1, 1'b0, 28'h4000001,   28'd0,         5'd27, 28'h8000000,   1'b1, 1'b1}, // R4 top pos
    '{1'b0, 1'b0, 1'b1, 1'b0, 28'h4000001,   28'd0,         5'd28, 28'h8000000,   1'b1, 1'b1}, // R5 clamp
    '{1'b0, 1'b0, 1'b1, 1'b0, 28'hFFFFFFC,   28'd0,         5'd3,  28'd0,         1'b0, 1'b1}  // R4 tie
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [27:0] a_data_i = '0;
  logic        a_valid_i = 1'b0;
  logic [27:0] b_data_i = '0;
  logic        b_valid_i = 1'b0;
  logic        sum_mode_i = 1'b0;
  logic        sel_b_i = 1'b0;
  logic [4:0]  rnd_pos_i = '0;
  logic        oe_lo_i = 1'b1;
  logic        oe_hi_i = 1'b1;
  logic [8:0]  out_lo_o;
  logic [18:0] out_hi_o;
  logic        valid_o;
  logic        ovf_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dual_fir_combiner i_dual_fir_combiner (
    .clk_i, .rst_ni, .a_data_i, .a_valid_i, .b_data_i, .b_valid_i,
    .sum_mode_i, .sel_b_i, .rnd_pos_i, .oe_lo_i, .oe_hi_i,
    .out_lo_o, .out_hi_o, .valid_o, .ovf_o
  );

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    sum_mode_i = v.mode; sel_b_i = v.sel;
    a_valid_i = v.va; b_valid_i = v.vb;
    a_data_i = v.a; b_data_i = v.b; rnd_pos_i = v.pos;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 reset data", {out_hi_o, out_lo_o}, 28'd0);
    chk("R9 reset valid", 28'(valid_o), 28'd0);
    chk("R9 reset ovf", 28'(ovf_o), 28'd0);
    rst_ni = 1'b1;

    // vector table, one new vector every clock
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        chk($sformatf("vec%0d data R1/R2/R4/R5", i - 1), {out_hi_o, out_lo_o}, VECS[i-1].exp);
        chk($sformatf("vec%0d ovf R3", i - 1), 28'(ovf_o), 28'(VECS[i-1].eovf));
        chk($sformatf("vec%0d valid R8", i - 1), 28'(valid_o), 28'(VECS[i-1].evld));
      end
      if (i < NV) drive(VECS[i]);
    end

    // R6 / R7: split halves and enables
    drive('{1'b0, 1'b0, 1'b1, 1'b0, 28'h1234ABC, 28'd0, 5'd0, 28'd0, 1'b0, 1'b0});
    @(negedge clk_i);
    chk("R6 low half", 28'(out_lo_o), 28'h0BC);
    chk("R6 high half", 28'(out_hi_o), 28'h1234ABC >> 9);
    oe_lo_i = 1'b0; #0.5;
    chk("R7 low disabled", 28'(out_lo_o), 28'd0);
    chk("R7 high untouched", 28'(out_hi_o), 28'h1234ABC >> 9);
    oe_lo_i = 1'b1; oe_hi_i = 1'b0; #0.5;
    chk("R7 high disabled", 28'(out_hi_o), 28'd0);
    chk("R7 low untouched", 28'(out_lo_o), 28'h0BC);
    oe_hi_i = 1'b1; #0.5;
    chk("R7 stored kept", {out_hi_o, out_lo_o}, 28'h1234ABC);

    // R9 latency: new input shows only after the next rising edge
    @(negedge clk_i);
    a_data_i = 28'h0055555;
    @(posedge clk_i); #0.1;
    chk("R9 one-cycle latency", {out_hi_o, out_lo_o}, 28'h0055555);

    // R9 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0; #0.5;
    chk("R9 async reset data", {out_hi_o, out_lo_o}, 28'd0);
    chk("R9 async reset valid", 28'(valid_o), 28'd0);

    done = 1'b1;
    finish_run();
  end
endmodule